// File: doc/BRIEF.md
# Cascaded DMA channel request arbiter

This block takes DMA service requests for a two-level, eight-position channel map and chooses one channel to serve. Channels 0 to 3 form a lower group. The lower group's single winner is presented upward as channel 4 of an upper group, which serves positions 4 to 7. Position 4 is fixed as the cascade link. It always carries the lower group's request and is never a channel of its own.

A request for a channel can come from a hardware request line driven by a DMA slave device. It can also come from a software request bit set through a simple register write port, and both sources count the same way. Per-channel mask bits suppress hardware requests only. When the block grants a channel it switches to master mode. It then drives a one-hot acknowledge and the encoded channel number, and keeps that grant until the transfer ends. The transfer ends on a terminal-count pulse or when the channel's request drops. With no grant the block is in slave mode and only accepts register writes.

No data moves through this block, so it has no valid/ready stream. All pins are plain control and status levels, sampled on the rising clock edge.

Top module: `dma_cascade_arb`

## Requirements
- R1: After reset, ack is 0, busy is 0 and active_chan is 0. All mask bits are set and all software request bits are clear, so a hardware request with no prior unmask write is not granted.
- R2: An unmasked hardware request on a channel, with no grant in progress, gives a grant at the next rising edge. ack then has exactly the bit of that channel set (bit n for channel n), active_chan holds n as a 3-bit binary number, and busy is 1.
- R3: A mask write (mask_we=1, wr_chan=n, wr_bit=1) sets the mask of channel n. A masked channel's hardware request is never granted. A mask write with wr_bit=0 clears the mask.
- R4: A request write (req_we=1, wr_chan=n, wr_bit=1) sets channel n's software request from the next edge on. That request is granted like a hardware one and is not affected by the mask. A request write with wr_bit=0 clears the bit.
- R5: Within the lower group, fixed priority applies among simultaneous requests: 0 first, then 1, 2, 3.
- R6: In the upper group, any lower-group request outranks channels 5, 6 and 7, which rank in that order.
- R7: A granted channel keeps the grant, with ack and active_chan unchanged, while its request stays up and tc is low, whatever higher-priority requests arrive.
- R8: tc high during a grant ends it at the next edge (ack 0, busy 0). The same edge clears the software request bit of the served channel. Re-arbitration starts on the following edge.
- R9: If the served channel's request falls while tc is low, the grant ends at the next edge.
- R10: Position 4 is never acknowledged. hw_req[4] and any request or mask write addressed to channel 4 have no effect on ack.
- R11: busy is 1 exactly when ack is non-zero. active_chan is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 8 | Hardware request per channel; bit 4 unused |
| req_we | input | 1 | Write wr_bit into the software request bit of wr_chan |
| mask_we | input | 1 | Write wr_bit into the mask bit of wr_chan |
| wr_chan | input | 3 | Channel addressed by a write |
| wr_bit | input | 1 | Value written |
| tc | input | 1 | Terminal count of the channel being served |
| ack | output | 8 | One-hot acknowledge of the served channel |
| active_chan | output | 3 | Binary number of the served channel, 0 when idle |
| busy | output | 1 | 1 in master mode (a grant is held), 0 in slave mode |

## Verification
Most internal faults become visible on ack one edge after the stimulus that exposes them. A wrong priority in either group picks the wrong channel on the first contended grant. A grant that releases too early or too late shows up in the cycle right after a tc pulse or a dropped request. A software bit that is not cleared on terminal count only appears one edge later, as an unwanted grant of a masked channel. The bench therefore checks every cycle and does not rely on final state.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_SLAVE  = 1'b0,
    ARB_MASTER = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_prio_enc.sv
// Fixed-priority picker: the lowest index among the raised inputs wins.
module dma_prio_enc #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_req_regs.sv
// Software request and mask bits. The cascade position holds constant values.
module dma_req_regs #(
  parameter int NCH  = 8,
  parameter int CASC = 4,
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_we,
  input  logic           mask_we,
  input  logic [CW-1:0]  wr_chan,
  input  logic           wr_bit,
  input  logic           tc_clr,
  input  logic [CW-1:0]  tc_chan,
  output logic [NCH-1:0] sw_req,
  output logic [NCH-1:0] mask
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == CASC) begin : g_casc
      assign sw_req[c] = 1'b0;
      assign mask[c]   = 1'b1;
    end else begin : g_prog
      logic sw_q, mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sw_q   <= 1'b0;
          mask_q <= 1'b1;
        end else begin
          // terminal count clear wins over a write in the same cycle
          if (tc_clr && tc_chan == CW'(c))       sw_q <= 1'b0;
          else if (req_we && wr_chan == CW'(c))  sw_q <= wr_bit;
          if (mask_we && wr_chan == CW'(c))      mask_q <= wr_bit;
        end
      end
      assign sw_req[c] = sw_q;
      assign mask[c]   = mask_q;
    end
  end

  AST_SW_CLEARED_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr |=> !sw_req[$past(tc_chan)]); // R8
endmodule

// File: rtl/dma_grant_ctl.sv
// Holds one grant until terminal count or the request drops.
module dma_grant_ctl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] eff_req,
  input  logic           win_any,
  input  logic [CW-1:0]  win_chan,
  input  logic           tc,
  output logic           busy,
  output logic [CW-1:0]  active_chan,
  output logic [NCH-1:0] ack
);
  arb_mode_e   mode_q;
  logic [CW-1:0] chan_q;
  logic        release_now;

  assign release_now = (mode_q == ARB_MASTER) && (tc || !eff_req[chan_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ARB_SLAVE;
      chan_q <= '0;
    end else if (mode_q == ARB_MASTER) begin
      if (release_now) begin
        mode_q <= ARB_SLAVE;
        chan_q <= '0;
      end
    end else if (win_any) begin
      mode_q <= ARB_MASTER;
      chan_q <= win_chan;
    end
  end

  assign busy        = (mode_q == ARB_MASTER);
  assign active_chan = chan_q;

  always_comb begin
    ack = '0;
    if (busy) ack[chan_q] = 1'b1;
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R2
  AST_BUSY_MATCHES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (ack != '0)); // R11
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tc && eff_req[chan_q] |=> busy && $stable(active_chan)); // R7
  AST_TC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tc |=> !busy); // R8
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb #(
  parameter int NCH = 8,
  localparam int GRP  = NCH / 2,
  localparam int CASC = GRP,
  localparam int CW   = $clog2(NCH),
  localparam int GW   = $clog2(GRP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic           req_we,
  input  logic           mask_we,
  input  logic [CW-1:0]  wr_chan,
  input  logic           wr_bit,
  input  logic           tc,
  output logic [NCH-1:0] ack,
  output logic [CW-1:0]  active_chan,
  output logic           busy
);
  logic [NCH-1:0] sw_req, mask, eff_req;
  logic           lower_any, upper_any;
  logic [GW-1:0]  lower_idx, upper_idx;
  logic [CW-1:0]  win_chan;
  logic [2:0]     unused_casc_bits;

  dma_req_regs #(.NCH(NCH), .CASC(CASC)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .mask_we(mask_we),
    .wr_chan(wr_chan), .wr_bit(wr_bit), .tc_clr(busy && tc),
    .tc_chan(active_chan), .sw_req(sw_req), .mask(mask)
  );

  // merged request per channel; the cascade slot carries the lower group
  for (genvar c = 0; c < NCH; c++) begin : g_eff
    if (c == CASC) begin : g_link
      assign eff_req[c] = lower_any;
    end else begin : g_chan
      assign eff_req[c] = (hw_req[c] && !mask[c]) || sw_req[c];
    end
  end
  assign unused_casc_bits = {hw_req[CASC], sw_req[CASC], mask[CASC]};

  dma_prio_enc #(.N(GRP)) u_lower (
    .req(eff_req[GRP-1:0]), .any(lower_any), .idx(lower_idx)
  );

  dma_prio_enc #(.N(GRP)) u_upper (
    .req(eff_req[NCH-1:GRP]), .any(upper_any), .idx(upper_idx)
  );

  assign win_chan = (upper_idx == '0) ? CW'(lower_idx) : CW'(GRP + int'(upper_idx));

  dma_grant_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .eff_req(eff_req), .win_any(upper_any),
    .win_chan(win_chan), .tc(tc), .busy(busy), .active_chan(active_chan),
    .ack(ack)
  );

  AST_WINNER_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
    upper_any |-> eff_req[win_chan] && win_chan != CW'(CASC)); // R5
  AST_NO_CASCADE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack[CASC]); // R10
  AST_IDLE_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> active_chan == '0); // R11
endmodule

// File: tb/dma_cascade_arb_tb.sv
module dma_cascade_arb_tb;
  typedef struct {
    logic [7:0] ack;
    logic       busy;
    logic [2:0] chan;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hw_req = '0;
  logic       req_we = 1'b0, mask_we = 1'b0, wr_bit = 1'b0, tc = 1'b0;
  logic [2:0] wr_chan = '0;
  logic [7:0] ack;
  logic [2:0] active_chan;
  logic       busy;

  exp_t q[$];
  int   total = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_cascade_arb u_dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .req_we(req_we),
    .mask_we(mask_we), .wr_chan(wr_chan), .wr_bit(wr_bit), .tc(tc),
    .ack(ack), .active_chan(active_chan), .busy(busy)
  );

  // driver: inputs for one cycle plus the expected outputs after its edge
  task automatic cyc(input logic [7:0] hw, input logic rq, input logic mk,
                     input int ch, input logic b, input logic t,
                     input int ec, input string tag);
    exp_t e;
    @(negedge clk);
    hw_req = hw; req_we = rq; mask_we = mk; wr_chan = 3'(ch); wr_bit = b; tc = t;
    e.ack  = (ec < 0) ? 8'h00 : 8'(1 << ec);
    e.busy = (ec >= 0);
    e.chan = (ec < 0) ? 3'd0 : 3'(ec);
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (ack !== e.ack || busy !== e.busy || active_chan !== e.chan) begin
          fails++;
          $display("FAIL %s: ack=%h busy=%b chan=%0d expected ack=%h busy=%b chan=%0d",
                   e.tag, ack, busy, active_chan, e.ack, e.busy, e.chan);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R1 reset idle");
    cyc(8'h01, 0, 0, 0, 0, 0, -1, "R1 masked after reset");
    cyc(8'h00, 0, 1, 0, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 1, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 2, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 3, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 5, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 6, 0, 0, -1, "R3 unmask");
    cyc(8'h00, 0, 1, 7, 0, 0, -1, "R3 unmask");
    cyc(8'h20, 0, 0, 0, 0, 0,  5, "R2 grant ch5");
    cyc(8'h21, 0, 0, 0, 0, 0,  5, "R7 no preempt by ch0");
    cyc(8'h01, 0, 0, 0, 0, 0, -1, "R9 drop releases");
    cyc(8'h01, 0, 0, 0, 0, 0,  0, "R2 grant ch0");
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R9 drop releases");
    cyc(8'hE2, 0, 0, 0, 0, 0,  1, "R6 lower group first");
    cyc(8'hE2, 0, 0, 0, 0, 1, -1, "R8 tc releases");
    cyc(8'hE0, 0, 0, 0, 0, 0,  5, "R6 ch5 over 6,7");
    cyc(8'hC0, 0, 0, 0, 0, 0, -1, "R9 drop releases");
    cyc(8'hC0, 0, 0, 0, 0, 0,  6, "R6 ch6 over 7");
    cyc(8'hC0, 0, 0, 0, 0, 1, -1, "R8 tc releases");
    cyc(8'h0C, 0, 0, 0, 0, 0,  2, "R5 ch2 over ch3");
    cyc(8'h0C, 0, 0, 0, 0, 1, -1, "R8 tc releases");
    cyc(8'h08, 0, 0, 0, 0, 0,  3, "R5 ch3 alone");
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R9 drop releases");
    cyc(8'h10, 0, 0, 0, 0, 0, -1, "R10 hw_req[4] ignored");
    cyc(8'h00, 1, 0, 4, 1, 0, -1, "R10 sw write ch4");
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R10 sw ch4 no effect");
    cyc(8'h10, 0, 1, 4, 0, 0, -1, "R10 mask write ch4");
    cyc(8'h10, 0, 0, 0, 0, 0, -1, "R10 unmask ch4 no effect");
    cyc(8'h00, 0, 1, 6, 1, 0, -1, "R3 mask ch6");
    cyc(8'h40, 0, 0, 0, 0, 0, -1, "R3 masked ch6 ignored");
    cyc(8'h40, 1, 0, 6, 1, 0, -1, "R4 sw write ch6");
    cyc(8'h40, 0, 0, 0, 0, 0,  6, "R4 sw grant despite mask");
    cyc(8'h41, 0, 0, 0, 0, 0,  6, "R7 hold against ch0");
    cyc(8'h40, 0, 0, 0, 0, 1, -1, "R8 tc releases");
    cyc(8'h40, 0, 0, 0, 0, 0, -1, "R8 sw bit cleared by tc");
    cyc(8'h00, 1, 0, 7, 1, 0, -1, "R4 sw write ch7");
    cyc(8'h00, 0, 0, 0, 0, 0,  7, "R4 sw grant ch7");
    cyc(8'h00, 1, 0, 7, 0, 0,  7, "R4 sw clear write");
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R9 cleared request releases");
    cyc(8'h00, 0, 0, 0, 0, 0, -1, "R11 idle chan zero");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule